// File: doc/BRIEF.md
# Handshaked Serial Command Transport

This block is the device end of a byte-at-a-time command link between a host processor and a power or system controller. The host writes a data byte into a shift-register input, sets a direction bit, and toggles two active-low handshake lines held in a port register. The block answers on the same port register, moves one byte per request, and raises a one-cycle shift-register interrupt for every byte it accepts.

A transaction has three phases. First comes a command byte. Next come its argument bytes, optionally preceded by a length byte. Last come the response bytes, optionally preceded by a size byte. A built-in length table, indexed by the command, decides how long the argument and response phases are. Once all the arguments are in, the block hands the command to an external executor through a start/done interface. The executor reads the argument buffer and fills the response buffer. Direction errors are flagged on a pulse output and transfer no byte.

Top module: `hsk_cmd_port`

## Requirements
- R1: After reset the port value is 0x18 (request line at bit 4 and acknowledge line at bit 3, both high, all other bits 0). The block is idle, and sr_irq, proto_err and exec_start are low.
- R2: A port write whose value equals the recorded port value has no effect. No interrupt or error is raised and the recorded value stays the same.
- R3: A changed write with request high and acknowledge low (a release) is recorded with the acknowledge bit forced high. No byte moves.
- R4: A changed write with request low and acknowledge high is a valid request. It is recorded with acknowledge forced low. If the direction is correct, exactly one byte moves and sr_irq pulses for one cycle. A write with both lines low is recorded and otherwise ignored.
- R5: The direction must be host-to-device (sr_dir=1) for command and argument bytes, and device-to-host (sr_dir=0) for response bytes. On a valid request with the wrong direction, or while the executor is busy, proto_err pulses for one cycle, sr_irq stays low, and no byte is consumed or produced.
- R6: In idle, the accepted byte becomes the command. Its lengths come from the table. Command bit 3 set means the argument length is in-band; otherwise the length is bits 2:0. Command bit 7 set means the response length is in-band; otherwise the length is bits 6:4.
- R7: When the argument length is in-band, the first byte after the command is the argument count and is not stored as an argument.
- R8: When the argument count reaches the length, exec_start pulses for exactly one cycle. At that time exec_cmd holds the command and exec_arg_cnt holds the count. A zero-length argument phase starts the executor with no further host byte.
- R9: Arguments beyond the 32-byte buffer are dropped but still counted in exec_arg_cnt. Stored argument i appears on exec_arg_data one cycle after exec_arg_addr=i.
- R10: After exec_done, each device-to-host request returns the next response byte. The response length is the table length. When that length is in-band, a first byte returns the size taken from exec_rsp_len.
- R11: If exec_unknown is high with exec_done, every response byte is zero. The length is the table length, and an in-band size is sent as 0.
- R12: After the last response byte (or at once, for a zero-length response), the block is idle again and the next accepted byte is a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_we | input | 1 | Host write strobe for the port register |
| port_wdata | input | 8 | Port value written by the host |
| port_val | output | 8 | Recorded port value, with the acknowledge line driven by the block |
| sr_in | input | 8 | Shift-register byte written by the host |
| sr_dir | input | 1 | 1 = host-to-device, 0 = device-to-host |
| sr_out | output | 8 | Byte returned to the host |
| sr_irq | output | 1 | One-cycle pulse per accepted byte |
| proto_err | output | 1 | One-cycle pulse on a rejected request |
| exec_start | output | 1 | One-cycle pulse: command ready for the executor |
| exec_cmd | output | 8 | Current command byte |
| exec_arg_cnt | output | 8 | Number of argument bytes received |
| exec_arg_addr | input | 5 | Executor read address into the argument buffer |
| exec_arg_data | output | 8 | Argument byte, one cycle after the address |
| exec_rsp_we | input | 1 | Executor write strobe into the response buffer |
| exec_rsp_addr | input | 5 | Response buffer write address |
| exec_rsp_wdata | input | 8 | Response buffer write data |
| exec_rsp_len | input | 8 | Response size for in-band-length commands |
| exec_unknown | input | 1 | Command not recognised; sampled with exec_done |
| exec_done | input | 1 | Executor finished |

## Verification
The hardest states to reach from the ports are the argument buffer overflow and the rejected response-phase request. The overflow needs an in-band argument length above the buffer size, so the bench sends a count of 40 and checks that exec_arg_cnt reports 40 while the first 32 bytes read back intact. For the rejected request, the bench parks the block in the response phase and issues a host-to-device request there. It then checks that the next correct request still returns the first response byte. The zero-length paths in both phases are reached through table entries whose lengths are zero.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_ARGS, PH_EXEC, PH_RSP} phase_t;

  localparam int N_CMD   = 256;
  localparam int ENT_W   = 16;
  localparam int TBL_W   = N_CMD * ENT_W;
  localparam int REQ_BIT = 4;
  localparam int ACK_BIT = 3;
  localparam logic signed [7:0] LEN_INBAND = -8'sd1;

  // Entry per command: {argument length, response length}, each signed 8 bit.
  function automatic logic [TBL_W-1:0] build_len_table();
    logic [TBL_W-1:0] t;
    logic [7:0] cb;
    logic [7:0] a_len;
    logic [7:0] r_len;
    t = '0;
    for (int c = 0; c < N_CMD; c++) begin
      cb    = 8'(c);
      a_len = cb[3] ? LEN_INBAND : {5'd0, cb[2:0]};
      r_len = cb[7] ? LEN_INBAND : {5'd0, cb[6:4]};
      t[c*ENT_W +: ENT_W] = {a_len, r_len};
    end
    return t;
  endfunction

endpackage

// File: rtl/hsk_len_rom.sv
module hsk_len_rom
  import hsk_pkg::*;
#(
  parameter logic [TBL_W-1:0] TABLE = build_len_table()
) (
  input  logic [7:0]        cmd,
  output logic signed [7:0] arg_len,
  output logic signed [7:0] rsp_len
);

  logic [ENT_W-1:0] entry;

  assign entry   = TABLE[{cmd, 4'b0000} +: ENT_W];
  assign arg_len = entry[15:8];
  assign rsp_len = entry[7:0];

endmodule

// File: rtl/hsk_sdp_ram.sv
module hsk_sdp_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/hsk_cmd_port.sv
module hsk_cmd_port
  import hsk_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int AW       = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          port_we,
  input  logic [7:0]    port_wdata,
  output logic [7:0]    port_val,
  input  logic [7:0]    sr_in,
  input  logic          sr_dir,
  output logic [7:0]    sr_out,
  output logic          sr_irq,
  output logic          proto_err,
  output logic          exec_start,
  output logic [7:0]    exec_cmd,
  output logic [7:0]    exec_arg_cnt,
  input  logic [AW-1:0] exec_arg_addr,
  output logic [7:0]    exec_arg_data,
  input  logic          exec_rsp_we,
  input  logic [AW-1:0] exec_rsp_addr,
  input  logic [7:0]    exec_rsp_wdata,
  input  logic [7:0]    exec_rsp_len,
  input  logic          exec_unknown,
  input  logic          exec_done
);

  localparam logic [7:0] ACK_MASK  = 8'(1 << ACK_BIT);
  localparam logic [7:0] IDLE_PORT = 8'((1 << REQ_BIT) | (1 << ACK_BIT));
  localparam logic [7:0] DEPTH8    = 8'(BUF_DEPTH);

  phase_t            ph;
  logic [7:0]        port_q, cmd_q, sro_q;
  logic              irq_q, err_q, start_q;
  logic [7:0]        arg_len, arg_cnt, rsp_len, rsp_ptr;
  logic              arg_inb, rsp_inb, zfill;
  logic signed [7:0] tbl_arg, tbl_rsp;
  logic [7:0]        rsp_rd;

  logic changed, valid_req, release_w, dir_ok, take, arg_we;

  assign changed   = port_we && (port_wdata != port_q);
  assign valid_req = changed && !port_wdata[REQ_BIT] && port_wdata[ACK_BIT];
  assign release_w = changed && port_wdata[REQ_BIT] && !port_wdata[ACK_BIT];
  assign dir_ok    = (ph == PH_RSP) ? !sr_dir : sr_dir;
  assign take      = valid_req && dir_ok && (ph != PH_EXEC);
  assign arg_we    = take && (ph == PH_ARGS) && !arg_inb && (arg_cnt < DEPTH8);

  hsk_len_rom u_rom (
    .cmd     (sr_in),
    .arg_len (tbl_arg),
    .rsp_len (tbl_rsp)
  );

  hsk_sdp_ram #(.W(8), .DEPTH(BUF_DEPTH)) u_arg_buf (
    .clk   (clk),
    .we    (arg_we),
    .waddr (arg_cnt[AW-1:0]),
    .wdata (sr_in),
    .raddr (exec_arg_addr),
    .rdata (exec_arg_data)
  );

  hsk_sdp_ram #(.W(8), .DEPTH(BUF_DEPTH)) u_rsp_buf (
    .clk   (clk),
    .we    (exec_rsp_we),
    .waddr (exec_rsp_addr),
    .wdata (exec_rsp_wdata),
    .raddr (rsp_ptr[AW-1:0]),
    .rdata (rsp_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      port_q  <= IDLE_PORT;
      cmd_q   <= '0;
      sro_q   <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      arg_len <= '0;
      arg_cnt <= '0;
      rsp_len <= '0;
      rsp_ptr <= '0;
      arg_inb <= 1'b0;
      rsp_inb <= 1'b0;
      zfill   <= 1'b0;
    end else begin
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      if (changed) begin
        if (release_w)      port_q <= port_wdata | ACK_MASK;
        else if (valid_req) port_q <= port_wdata & ~ACK_MASK;
        else                port_q <= port_wdata;
      end
      if (valid_req && !take) err_q <= 1'b1;
      if (take) begin
        irq_q <= 1'b1;
        unique case (ph)
          PH_IDLE: begin
            cmd_q   <= sr_in;
            arg_inb <= (tbl_arg == LEN_INBAND);
            arg_len <= (tbl_arg == LEN_INBAND) ? 8'd0 : tbl_arg;
            rsp_inb <= (tbl_rsp == LEN_INBAND);
            rsp_len <= (tbl_rsp == LEN_INBAND) ? 8'd0 : tbl_rsp;
            arg_cnt <= '0;
            rsp_ptr <= '0;
            zfill   <= 1'b0;
            ph      <= PH_ARGS;
          end
          PH_ARGS: begin
            if (arg_inb) begin
              arg_len <= sr_in;
              arg_inb <= 1'b0;
            end else begin
              arg_cnt <= arg_cnt + 8'd1;
            end
          end
          PH_RSP: begin
            if (rsp_inb) begin
              sro_q   <= rsp_len;
              rsp_inb <= 1'b0;
            end else if (rsp_ptr < rsp_len) begin
              sro_q   <= (zfill || rsp_ptr >= DEPTH8) ? 8'd0 : rsp_rd;
              rsp_ptr <= rsp_ptr + 8'd1;
            end
          end
          default: ;
        endcase
      end else begin
        if (ph == PH_ARGS && !arg_inb && arg_cnt == arg_len) begin
          start_q <= 1'b1;
          ph      <= PH_EXEC;
        end
        if (ph == PH_EXEC && exec_done) begin
          if (rsp_inb) rsp_len <= exec_unknown ? 8'd0 : exec_rsp_len;
          zfill <= exec_unknown;
          ph    <= PH_RSP;
        end
        if (ph == PH_RSP && !rsp_inb && rsp_ptr == rsp_len) ph <= PH_IDLE;
      end
    end
  end

  assign port_val     = port_q;
  assign sr_out       = sro_q;
  assign sr_irq       = irq_q;
  assign proto_err    = err_q;
  assign exec_start   = start_q;
  assign exec_cmd     = cmd_q;
  assign exec_arg_cnt = arg_cnt;

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(port_we) |-> $stable(port_q)); // R2
  AST_ACK_LOW_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !port_q[ACK_BIT]); // R4
  AST_ERR_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    !(irq_q && err_q)); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q); // R8
  AST_START_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (ph == PH_EXEC)); // R8
  AST_RSP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RSP) |-> (rsp_ptr <= rsp_len)); // R10

endmodule

// File: tb/hsk_cmd_port_test.sv
module hsk_cmd_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {cmd, in-band argument count, executor response size, unknown}
  localparam logic [24:0] VEC [NVEC] = '{
    {8'h00, 8'd0, 8'd0, 1'b0},
    {8'h23, 8'd0, 8'd0, 1'b0},
    {8'h88, 8'd2, 8'd3, 1'b0},
    {8'h31, 8'd0, 8'd0, 1'b1},
    {8'h80, 8'd0, 8'd5, 1'b1},
    {8'h0C, 8'd0, 8'd0, 1'b0},
    {8'h8F, 8'd3, 8'd2, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_we = 1'b0;
  logic [7:0] port_wdata = 8'h18;
  logic [7:0] port_val;
  logic [7:0] sr_in = 8'h00;
  logic       sr_dir = 1'b1;
  logic [7:0] sr_out;
  logic       sr_irq, proto_err, exec_start;
  logic [7:0] exec_cmd, exec_arg_cnt, exec_arg_data;
  logic [4:0] exec_arg_addr = '0;
  logic       exec_rsp_we = 1'b0;
  logic [4:0] exec_rsp_addr = '0;
  logic [7:0] exec_rsp_wdata = '0;
  logic [7:0] exec_rsp_len = '0;
  logic       exec_unknown = 1'b0;
  logic       exec_done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int start_count = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (!rst && exec_start) start_count++;

  hsk_cmd_port uut (
    .clk(clk), .rst(rst), .port_we(port_we), .port_wdata(port_wdata),
    .port_val(port_val), .sr_in(sr_in), .sr_dir(sr_dir), .sr_out(sr_out),
    .sr_irq(sr_irq), .proto_err(proto_err), .exec_start(exec_start),
    .exec_cmd(exec_cmd), .exec_arg_cnt(exec_arg_cnt),
    .exec_arg_addr(exec_arg_addr), .exec_arg_data(exec_arg_data),
    .exec_rsp_we(exec_rsp_we), .exec_rsp_addr(exec_rsp_addr),
    .exec_rsp_wdata(exec_rsp_wdata), .exec_rsp_len(exec_rsp_len),
    .exec_unknown(exec_unknown), .exec_done(exec_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic host_write(input logic [7:0] v);
    port_we = 1'b1;
    port_wdata = v;
    @(negedge clk);
    port_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    sr_in = b;
    sr_dir = 1'b1;
    host_write(8'h08);
    chk({tag, " byte accepted irq"}, sr_irq, 1);
    chk("R4 ack driven low", port_val, 8'h00);
    host_write(8'h10);
    chk("R3 release raises ack", port_val, 8'h18);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sr_dir = 1'b0;
    host_write(8'h08);
    chk("R4 response irq", sr_irq, 1);
    b = sr_out;
    host_write(8'h10);
    sr_dir = 1'b1;
  endtask

  function automatic logic [7:0] arg_val(input logic [7:0] cmd, input int i);
    return cmd ^ 8'(i * 7 + 3);
  endfunction

  task automatic xact(input logic [7:0] cmd, input int nargs, input int exec_n, input bit unk);
    int alen, rlen, wn, s0, t;
    logic [7:0] b;
    alen = cmd[3] ? nargs : int'(cmd[2:0]);
    rlen = cmd[7] ? (unk ? 0 : exec_n) : int'(cmd[6:4]);
    wn   = cmd[7] ? exec_n : int'(cmd[6:4]);
    s0 = start_count;
    send_byte(cmd, "R12 new command");
    if (cmd[3]) send_byte(8'(nargs), "R7 length byte");
    for (int i = 0; i < alen; i++) send_byte(arg_val(cmd, i), "R4 argument");
    t = 0;
    while (start_count == s0 && t < 50) begin @(negedge clk); t++; end
    @(negedge clk);
    chk("R8 single start pulse", start_count - s0, 1);
    chk("R8 exec_cmd", exec_cmd, cmd);
    chk(cmd[3] ? "R7 in-band arg count" : "R6 table arg count", exec_arg_cnt, alen);
    for (int i = 0; i < ((alen < 32) ? alen : 32); i++) begin
      exec_arg_addr = 5'(i);
      @(negedge clk);
      chk("R9 stored argument", exec_arg_data, arg_val(cmd, i));
    end
    if (!unk) begin
      for (int i = 0; i < wn; i++) begin
        exec_rsp_we = 1'b1;
        exec_rsp_addr = 5'(i);
        exec_rsp_wdata = cmd + 8'(i + 1);
        @(negedge clk);
      end
      exec_rsp_we = 1'b0;
    end
    exec_rsp_len = 8'(exec_n);
    exec_unknown = unk;
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    exec_unknown = 1'b0;
    if (cmd[7]) begin
      recv_byte(b);
      chk(unk ? "R11 in-band size zero" : "R10 in-band size", b, rlen);
    end
    for (int i = 0; i < rlen; i++) begin
      recv_byte(b);
      chk(unk ? "R11 zero response" : "R10 response byte", b,
          unk ? 0 : int'(cmd + 8'(i + 1)));
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] b;
    int s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset port", port_val, 8'h18);
    chk("R1 reset irq", sr_irq, 0);
    chk("R1 reset err", proto_err, 0);
    chk("R1 reset start", exec_start, 0);

    host_write(8'h18);
    chk("R2 same value no irq", sr_irq, 0);
    chk("R2 same value port", port_val, 8'h18);

    host_write(8'h00);
    chk("R4 both low no irq", sr_irq, 0);
    chk("R4 both low recorded", port_val, 8'h00);
    host_write(8'h18);

    sr_dir = 1'b0;
    host_write(8'h08);
    chk("R5 idle wrong dir err", proto_err, 1);
    chk("R5 idle wrong dir irq", sr_irq, 0);
    host_write(8'h10);
    sr_dir = 1'b1;

    for (int v = 0; v < NVEC; v++)
      xact(VEC[v][24:17], int'(VEC[v][16:9]), int'(VEC[v][8:1]), VEC[v][0]);

    xact(8'h08, 40, 0, 1'b0);  // R9 overflow past buffer

    s0 = start_count;
    send_byte(8'h10, "R6 one-byte response cmd");
    repeat (3) @(negedge clk);
    chk("R8 zero args start", start_count - s0, 1);
    exec_rsp_we = 1'b1; exec_rsp_addr = 5'd0; exec_rsp_wdata = 8'h5A;
    @(negedge clk);
    exec_rsp_we = 1'b0;
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    sr_dir = 1'b1;
    host_write(8'h08);
    chk("R5 rsp wrong dir err", proto_err, 1);
    chk("R5 rsp wrong dir irq", sr_irq, 0);
    host_write(8'h10);
    recv_byte(b);
    chk("R5 byte not consumed", b, 8'h5A);
    @(negedge clk);
    send_byte(8'h00, "R12 idle after response");
    repeat (3) @(negedge clk);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end

endmodule